// File: doc/BRIEF.md
# Hybrid Per-Chain Scan-Enable Test Wrapper

This block wraps a small combinational logic cloud with several equal-length scan chains for transition-delay testing. A single slow global scan enable comes from the tester. Each chain begins with one enable-generator cell. That cell is itself a scan stage. It takes a control bit that is shifted in as the last bit of every pattern, and it drives the scan-enable pin of every flip-flop in its own chain.

A parameter mask chooses which chains get a fast generator and which get a slow one. A fast generator keeps its chain shifting for exactly one edge after the global enable falls and then drops to functional capture. This is launch from the shift path. A slow generator holds its control bit for as long as the global enable stays low. A chain with control bit 0 launches and captures through the functional path, whichever variant it has. Because every chain decodes its own control bit, a single pattern can mix shift-launch chains, shift-only chains and functional chains.

Each test runs in this order. The global enable is held high for CHAIN_LEN+1 shift cycles. It is then held low for a launch edge and a capture edge. It then goes high again so that the response is shifted out while the next pattern is shifted in.

Top module: `hyscan_wrap`

## Requirements
- R1: A synchronous active-high reset clears every payload flip-flop and every control cell. An unload that follows reset returns all zeros on every chain.
- R2: While the global enable is 1, every chain shifts one place per rising edge. The order is scan input, then control cell, then payload flops 0 to CHAIN_LEN-1, then scan output. After CHAIN_LEN+1 shifts, the control cell holds the last bit shifted in, and payload flop j holds the bit shifted in at step CHAIN_LEN-1-j.
- R3: For a fast chain whose control bit is 1, the launch edge shifts: flop 0 takes the control value and flop j takes flop j-1. The capture edge then loads the functional D value into every flop of the chain.
- R4: For a slow chain whose control bit is 1, both the launch edge and the capture edge shift. The chain captures no functional value.
- R5: For a chain of either variant whose control bit is 0, both the launch edge and the capture edge load functional D values.
- R6: Once the global enable is low, a fast control cell reads 0 after its first edge. A slow control cell keeps its value. The control value is the last of CHAIN_LEN+1 bits unloaded, after the payload bits.
- R7: With flat flop index k = chain*CHAIN_LEN + position, the functional D of flop k is state[(k+1) mod N] XOR func_in[k], where N is the total number of flops.
- R8: func_out[k] = state[k] XOR state[(k+N-1) mod N], as a combinational function of the current flop state.
- R9: Chains act independently within one pattern. Fast, slow, 1 and 0 control bits can be combined freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test and functional clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gse | input | 1 | Global slow scan enable, routed only to the generator cells |
| scan_in | input | NUM_CHAINS | Serial input of each chain |
| scan_out | output | NUM_CHAINS | Serial output of each chain (last payload flop) |
| func_in | input | NUM_CHAINS*CHAIN_LEN | Functional inputs of the logic under test |
| func_out | output | NUM_CHAINS*CHAIN_LEN | Functional outputs of the logic under test |

## Verification
The assertions assume that gse stays high for at least CHAIN_LEN+1 edges before each launch. They also assume that it stays low for exactly two edges, so that the sequence is launch, capture and then a return to shifting. The control-cell properties then describe one well-formed launch window. The stimulus drives gse only through a load, launch-capture and unload task sequence, and it changes inputs only on falling edges. Every pattern therefore keeps to this window shape, and no other gse timing reaches the design.

// File: rtl/hyscan_pkg.sv
package hyscan_pkg;

    typedef enum logic {
        GEN_SLOW = 1'b0,
        GEN_FAST = 1'b1
    } gen_kind_e;

    typedef struct packed {
        logic ctrl;
        logic lsen;
    } gen_out_t;

    function automatic int ring_next(input int k, input int n);
        return (k + 1) % n;
    endfunction

    function automatic int ring_prev(input int k, input int n);
        return (k + n - 1) % n;
    endfunction

endpackage

// File: rtl/hyscan_gen_cell.sv
module hyscan_gen_cell
    import hyscan_pkg::*;
#(
    parameter gen_kind_e KIND = GEN_SLOW
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     gse,
    input  logic     si,
    output gen_out_t gen
);

    logic ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
        end else if (gse) begin
            ctrl_q <= si;
        end else if (KIND == GEN_FAST) begin
            ctrl_q <= 1'b0;
        end
    end

    always_comb begin
        gen.ctrl = ctrl_q;
        gen.lsen = gse | ctrl_q;
    end

    AST_CTRL_CLEAR: assert property (@(posedge clk) rst |=> !ctrl_q); // R1

    generate
        if (KIND == GEN_FAST) begin : g_fast
            AST_FAST_DROP: assert property (@(posedge clk) disable iff (rst)
                !gse |=> (gse || !gen.lsen)); // R6
        end else begin : g_slow
            AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
                !gse |=> (gse || gen.lsen == $past(gen.lsen))); // R6
        end
    endgenerate

endmodule

// File: rtl/hyscan_chain.sv
module hyscan_chain
    import hyscan_pkg::*;
#(
    parameter int        LEN  = 4,
    parameter gen_kind_e KIND = GEN_SLOW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           gse,
    input  logic           si,
    input  logic [LEN-1:0] d_func,
    output logic [LEN-1:0] q,
    output logic           so
);

    gen_out_t       gen;
    logic [LEN-1:0] shift_src;

    hyscan_gen_cell #(.KIND(KIND)) u_gen (
        .clk (clk),
        .rst (rst),
        .gse (gse),
        .si  (si),
        .gen (gen)
    );

    assign shift_src = {q[LEN-2:0], gen.ctrl};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (gen.lsen) begin
            q <= shift_src;
        end else begin
            q <= d_func;
        end
    end

    assign so = q[LEN-1];

    AST_SHIFT_PATH: assert property (@(posedge clk) disable iff (rst)
        gen.lsen |=> q == $past(shift_src)); // R2
    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !gen.lsen |=> q == $past(d_func)); // R5

endmodule

// File: rtl/hyscan_logic.sv
module hyscan_logic
    import hyscan_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] state,
    input  logic [N-1:0] fin,
    output logic [N-1:0] dnext,
    output logic [N-1:0] fout
);

    generate
        for (genvar k = 0; k < N; k++) begin : g_bit
            localparam int NXT = ring_next(k, N);
            localparam int PRV = ring_prev(k, N);
            assign dnext[k] = state[NXT] ^ fin[k];
            assign fout[k]  = state[k] ^ state[PRV];
        end
    endgenerate

endmodule

// File: rtl/hyscan_wrap.sv
module hyscan_wrap
    import hyscan_pkg::*;
#(
    parameter int                    NUM_CHAINS = 4,
    parameter int                    CHAIN_LEN  = 4,
    parameter logic [NUM_CHAINS-1:0] FAST_MASK  = 'b0001
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            gse,
    input  logic [NUM_CHAINS-1:0]           scan_in,
    output logic [NUM_CHAINS-1:0]           scan_out,
    input  logic [NUM_CHAINS*CHAIN_LEN-1:0] func_in,
    output logic [NUM_CHAINS*CHAIN_LEN-1:0] func_out
);

    localparam int N = NUM_CHAINS * CHAIN_LEN;

    logic [N-1:0] state;
    logic [N-1:0] dnext;

    hyscan_logic #(.N(N)) u_logic (
        .state (state),
        .fin   (func_in),
        .dnext (dnext),
        .fout  (func_out)
    );

    generate
        for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
            localparam gen_kind_e KIND = FAST_MASK[c] ? GEN_FAST : GEN_SLOW;
            hyscan_chain #(.LEN(CHAIN_LEN), .KIND(KIND)) u_chain (
                .clk    (clk),
                .rst    (rst),
                .gse    (gse),
                .si     (scan_in[c]),
                .d_func (dnext[c*CHAIN_LEN +: CHAIN_LEN]),
                .q      (state[c*CHAIN_LEN +: CHAIN_LEN]),
                .so     (scan_out[c])
            );
        end
    endgenerate

endmodule

// File: tb/hyscan_wrap_test.sv
module hyscan_wrap_test;

    localparam int C = 4;
    localparam int L = 4;
    localparam int N = C * L;
    localparam logic [C-1:0] FAST = 4'b0001;

    // {ctrl[3:0], payload[15:0], func_in[15:0]}
    localparam logic [35:0] VEC [4] = '{
        {4'b1111, 16'hA5C3, 16'h0F0F},
        {4'b0000, 16'h3C96, 16'hF00F},
        {4'b0101, 16'h7E81, 16'h1234},
        {4'b1010, 16'hFFFF, 16'h0000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         gse = 1'b1;
    logic [C-1:0] scan_in = '0;
    logic [C-1:0] scan_out;
    logic [N-1:0] func_in = '0;
    logic [N-1:0] func_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    logic [N-1:0] st;
    logic [C-1:0] ctl;
    logic [L:0]   got [C];

    always #10 clk = ~clk;

    hyscan_wrap #(.NUM_CHAINS(C), .CHAIN_LEN(L), .FAST_MASK(FAST)) uut (
        .clk      (clk),
        .rst      (rst),
        .gse      (gse),
        .scan_in  (scan_in),
        .scan_out (scan_out),
        .func_in  (func_in),
        .func_out (func_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [C-1:0] cbits, input logic [N-1:0] pay);
        for (int s = 0; s <= L; s++) begin
            gse = 1'b1;
            for (int c = 0; c < C; c++)
                scan_in[c] = (s < L) ? pay[c*L + (L-1-s)] : cbits[c];
            @(posedge clk);
            @(negedge clk);
        end
        st  = pay;
        ctl = cbits;
    endtask

    task automatic unload();
        gse = 1'b1;
        scan_in = '0;
        for (int k = 0; k <= L; k++) begin
            for (int c = 0; c < C; c++) got[c][k] = scan_out[c];
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic model_edge();
        logic [N-1:0] dn, ns;
        logic [C-1:0] nc;
        for (int k = 0; k < N; k++) dn[k] = st[(k+1) % N] ^ func_in[k];
        for (int c = 0; c < C; c++) begin
            for (int j = 0; j < L; j++) begin
                if (ctl[c]) ns[c*L+j] = (j == 0) ? ctl[c] : st[c*L+j-1];
                else        ns[c*L+j] = dn[c*L+j];
            end
            nc[c] = FAST[c] ? 1'b0 : ctl[c];
        end
        st  = ns;
        ctl = nc;
    endtask

    function automatic logic [L:0] expect_chain(input int c);
        logic [L:0] e;
        for (int k = 0; k < L; k++) e[k] = st[c*L + L-1-k];
        e[L] = ctl[c];
        return e;
    endfunction

    function automatic logic [N-1:0] expect_fout(input logic [N-1:0] s);
        logic [N-1:0] f;
        for (int k = 0; k < N; k++) f[k] = s[k] ^ s[(k+N-1) % N];
        return f;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: zeros after reset
        unload();
        for (int c = 0; c < C; c++) check("R1 reset unload", 32'(got[c]), 32'(0));

        // Vector table: load, launch, capture, unload
        for (int v = 0; v < 4; v++) begin
            logic [C-1:0] cb;
            cb      = VEC[v][35:32];
            func_in = VEC[v][15:0];
            load(cb, VEC[v][31:16]);
            check("R8 func_out after load", 32'(func_out), 32'(expect_fout(st)));
            gse = 1'b0;
            @(posedge clk); model_edge();
            @(negedge clk);
            @(posedge clk); model_edge();
            @(negedge clk);
            unload();
            for (int c = 0; c < C; c++) begin
                string req;
                if (!cb[c])       req = "R5 R7 functional chain";
                else if (FAST[c]) req = "R3 R6 R7 fast shift-launch chain";
                else              req = "R4 R6 slow shift-only chain";
                if (v == 2) req = {req, " R9 mixed"};
                check(req, 32'(got[c]), 32'(expect_chain(c)));
            end
        end

        // R2: shift-through with the enable held high
        load(4'b1001, 16'h9A3C);
        unload();
        for (int c = 0; c < C; c++) check("R2 shift order", 32'(got[c]), 32'(expect_chain(c)));

        // R1: reset mid-pattern clears loaded state
        load(4'b1111, 16'hFFFF);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        st = '0; ctl = '0;
        unload();
        for (int c = 0; c < C; c++) check("R1 reset after load", 32'(got[c]), 32'(expect_chain(c)));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule